// File: doc/BRIEF.md
# Multi-Context TLB Lookup with External Context Override

This block is a fully associative, software-loaded translation table for data and fetch accesses. Each request presents a 32-bit effective address, a write flag, an access mode and a fetch flag. The block returns the real address (a 4 KiB page frame joined with the page offset), a hit flag, a miss flag, a permission-fault flag and a two-bit fault syndrome. The result appears one clock after the request.

In the normal mode the lookup uses the processor state: the primary process ID, two optional secondary process IDs, the problem-state bit and the data- or instruction-relocate bit. Two extra modes, external load and external store, take their whole context instead from one of two writable context registers. Each register holds a process ID, an address-space bit and a privilege bit. Hypervisor code uses these modes to reach another address space. Each external mode keeps a one-entry translation cache. The cache is a two-state machine with the states `UC_EMPTY` and `UC_VALID`. A table hit in that mode moves it from `UC_EMPTY` to `UC_VALID` (a refill), or refills it while it is already in `UC_VALID`. A write to that mode's context register, or any write to the table, moves it back to `UC_EMPTY` (a flush). When the flush and the refill come in the same cycle, the flush wins.

Top module: `eptlb_lookup`

## Requirements
- R1: A request with `req_valid` high at a rising edge gives `rsp_valid` high after that edge, for exactly one cycle. In the normal mode an entry matches when it is valid, its page number equals address bits 31:12, and its TID equals `cpu_pid0` or is 0 (a global entry). On a hit without a fault, `rsp_raddr` = {entry RPN, address bits 11:0}.
- R2: In the normal mode an entry also matches through `cpu_pid1` when `cpu_pid1` is nonzero, and through `cpu_pid2` when `cpu_pid2` is nonzero.
- R3: In the external modes (`req_mode` 1 = external load, 2 = external store) only the selected context register's PID (bits 7:0) is matched. `cpu_pid0`, `cpu_pid1` and `cpu_pid2` have no effect.
- R4: External load uses the load context register and external store uses the store context register. `req_mode` 0 and 3 are the normal mode.
- R5: A context register write keeps only bits 7:0 (PID), 30 (address space) and 31 (privilege). All other bits read back as 0 on `ctx_ld_q` / `ctx_st_q`. Both registers reset to 0.
- R6: Permission bits are bit 3 user-read, bit 2 user-write, bit 1 supervisor-read and bit 0 supervisor-write. User bits apply when the privilege in effect is 1: context bit 31 in the external modes, `cpu_pr` otherwise. Supervisor bits apply when it is 0.
- R7: An entry whose TS bit differs from the effective address-space bit does not match. That bit is context bit 30 in the external modes, `cpu_ds` for normal data accesses and `cpu_is` for fetches.
- R8: `rsp_syn` is 0 unless there is a miss or a fault. On a miss or fault, bit 0 is set for a write and bit 1 is set for an external-mode access.
- R9: A fault (`rsp_fault`) is a hit without permission and is distinct from `rsp_miss`. `rsp_raddr` is 0 on a miss or a fault.
- R10: An external-mode table hit, with or without a fault, loads that mode's cache. A later access in the same mode to the same page is answered from it, with `rsp_cached` set.
- R11: A context register write flushes only that mode's cache. A table write flushes both caches.
- R12: A fetch (`req_fetch`) always uses the normal context whatever `req_mode` says. It is treated as a read and never sets syndrome bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_mode | input | 2 | 0 normal, 1 external load, 2 external store, 3 normal |
| req_fetch | input | 1 | Instruction fetch |
| cpu_pid0 | input | 8 | Primary process ID |
| cpu_pid1 | input | 8 | Secondary process ID 1 (0 = unused) |
| cpu_pid2 | input | 8 | Secondary process ID 2 (0 = unused) |
| cpu_pr | input | 1 | Processor problem-state (user) bit |
| cpu_ds | input | 1 | Data address-space bit |
| cpu_is | input | 1 | Instruction address-space bit |
| ctx_ld_we | input | 1 | Write the load context register |
| ctx_st_we | input | 1 | Write the store context register |
| ctx_wdata | input | 32 | Context write data |
| ctx_ld_q | output | 32 | Load context register contents |
| ctx_st_q | output | 32 | Store context register contents |
| tlb_we | input | 1 | Table entry write |
| tlb_idx | input | 3 | Entry index |
| tlb_valid | input | 1 | Entry valid |
| tlb_tid | input | 8 | Entry TID (0 = global) |
| tlb_ts | input | 1 | Entry translation space |
| tlb_epn | input | 20 | Effective page number |
| tlb_rpn | input | 20 | Real page number |
| tlb_perm | input | 4 | UR, UW, SR, SW (bit 3 down to 0) |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation |
| rsp_fault | output | 1 | Hit without permission |
| rsp_raddr | output | 32 | Real address |
| rsp_syn | output | 2 | Bit 1 external, bit 0 store |
| rsp_cached | output | 1 | Answer came from a mode cache |

## Verification
A stale cache state shows up at once as `rsp_cached` set on the first external access after a context or table write. It also shows as a translation or privilege that the new register value should have changed. A wrong context selection shows on the very next response, as a miss where a hit was expected or as a syndrome with the wrong external bit. A mask fault in a context register is visible on its readback port one cycle after the write. It also appears as a wrong address-space match on the next external lookup.

// File: rtl/eptlb_pkg.sv
package eptlb_pkg;
    parameter int PID_W      = 8;
    parameter int PN_W       = 20;
    parameter int OFF_W      = 12;
    parameter int VA_W       = PN_W + OFF_W;
    parameter int CTX_W      = 32;
    parameter int PERM_W     = 4;
    parameter int SYN_W      = 2;

    localparam int CTX_AS_BIT = CTX_W - 2;
    localparam int CTX_PR_BIT = CTX_W - 1;
    localparam logic [CTX_W-1:0] CTX_KEEP =
        {2'b11, {(CTX_W-2-PID_W){1'b0}}, {PID_W{1'b1}}};

    localparam int PERM_SW = 0;
    localparam int PERM_SR = 1;
    localparam int PERM_UW = 2;
    localparam int PERM_UR = 3;

    localparam int SYN_ST  = 0;
    localparam int SYN_EXT = 1;

    typedef enum logic [1:0] {
        AM_NORMAL    = 2'd0,
        AM_EXT_LOAD  = 2'd1,
        AM_EXT_STORE = 2'd2,
        AM_RESERVED  = 2'd3
    } acc_mode_e;

    typedef enum logic {
        UC_EMPTY = 1'b0,
        UC_VALID = 1'b1
    } uc_state_e;

    typedef struct packed {
        logic              valid;
        logic [PID_W-1:0]  tid;
        logic              ts;
        logic [PN_W-1:0]   epn;
        logic [PN_W-1:0]   rpn;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;
endpackage

// File: rtl/eptlb_ctx_reg.sv
module eptlb_ctx_reg
    import eptlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTX_W-1:0] wdata,
    output logic [CTX_W-1:0] q,
    output logic [PID_W-1:0] ctx_pid,
    output logic             ctx_as,
    output logic             ctx_pr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & CTX_KEEP;
        end
    end

    assign ctx_pid = q[PID_W-1:0];
    assign ctx_as  = q[CTX_AS_BIT];
    assign ctx_pr  = q[CTX_PR_BIT];
endmodule

// File: rtl/eptlb_array.sv
module eptlb_array
    import eptlb_pkg::*;
#(
    parameter int NENT  = 8,
    parameter int IDX_W = $clog2(NENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic [PN_W-1:0]   lk_pn,
    input  logic [PID_W-1:0]  lk_pid0,
    input  logic              lk_pid1_en,
    input  logic [PID_W-1:0]  lk_pid1,
    input  logic              lk_pid2_en,
    input  logic [PID_W-1:0]  lk_pid2,
    input  logic              lk_as,
    output logic              lk_hit,
    output logic [PN_W-1:0]   lk_rpn,
    output logic [PERM_W-1:0] lk_perm
);
    tlb_ent_t            ents [NENT];
    logic [NENT-1:0]     match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ents[i] <= '0;
            end
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end

    function automatic logic tid_ok(input logic [PID_W-1:0] tid,
                                    input logic [PID_W-1:0] pid);
        return (tid == '0) || (tid == pid);
    endfunction

    generate
        for (genvar gi = 0; gi < NENT; gi++) begin : g_cmp
            logic ctx_ok;
            assign ctx_ok = tid_ok(ents[gi].tid, lk_pid0)
                         || (lk_pid1_en && tid_ok(ents[gi].tid, lk_pid1))
                         || (lk_pid2_en && tid_ok(ents[gi].tid, lk_pid2));
            assign match[gi] = ents[gi].valid
                            && (ents[gi].epn == lk_pn)
                            && (ents[gi].ts == lk_as)
                            && ctx_ok;
        end
    endgenerate

    always_comb begin
        lk_rpn  = '0;
        lk_perm = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_rpn  = ents[i].rpn;
                lk_perm = ents[i].perm;
            end
        end
    end

    assign lk_hit = |match;
endmodule

// File: rtl/eptlb_ucache.sv
module eptlb_ucache
    import eptlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill,
    input  logic [PN_W-1:0]   fill_pn,
    input  logic [PN_W-1:0]   fill_rpn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic [PN_W-1:0]   lk_pn,
    output logic              lk_hit,
    output logic [PN_W-1:0]   lk_rpn,
    output logic [PERM_W-1:0] lk_perm
);
    uc_state_e         state, state_nx;
    logic [PN_W-1:0]   tag_q;
    logic [PN_W-1:0]   rpn_q;
    logic [PERM_W-1:0] perm_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            UC_EMPTY: if (fill && !flush) state_nx = UC_VALID;
            UC_VALID: if (flush)          state_nx = UC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= UC_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            rpn_q  <= '0;
            perm_q <= '0;
        end else if (fill && !flush) begin
            tag_q  <= fill_pn;
            rpn_q  <= fill_rpn;
            perm_q <= fill_perm;
        end
    end

    assign lk_hit  = (state == UC_VALID) && (tag_q == lk_pn);
    assign lk_rpn  = rpn_q;
    assign lk_perm = perm_q;
endmodule

// File: rtl/eptlb_lookup.sv
module eptlb_lookup
    import eptlb_pkg::*;
#(
    parameter int NENT  = 8,
    parameter int IDX_W = $clog2(NENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic              req_fetch,
    input  logic [PID_W-1:0]  cpu_pid0,
    input  logic [PID_W-1:0]  cpu_pid1,
    input  logic [PID_W-1:0]  cpu_pid2,
    input  logic              cpu_pr,
    input  logic              cpu_ds,
    input  logic              cpu_is,
    input  logic              ctx_ld_we,
    input  logic              ctx_st_we,
    input  logic [CTX_W-1:0]  ctx_wdata,
    output logic [CTX_W-1:0]  ctx_ld_q,
    output logic [CTX_W-1:0]  ctx_st_q,
    input  logic              tlb_we,
    input  logic [IDX_W-1:0]  tlb_idx,
    input  logic              tlb_valid,
    input  logic [PID_W-1:0]  tlb_tid,
    input  logic              tlb_ts,
    input  logic [PN_W-1:0]   tlb_epn,
    input  logic [PN_W-1:0]   tlb_rpn,
    input  logic [PERM_W-1:0] tlb_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_raddr,
    output logic [SYN_W-1:0]  rsp_syn,
    output logic              rsp_cached
);
    localparam int NCTX = 2;

    acc_mode_e mode;
    assign mode = acc_mode_e'(req_mode);

    // context registers: index 0 load, index 1 store
    logic [CTX_W-1:0] ctx_q   [NCTX];
    logic [PID_W-1:0] ctx_pid [NCTX];
    logic             ctx_as  [NCTX];
    logic             ctx_pr  [NCTX];
    logic [NCTX-1:0]  ctx_we;
    assign ctx_we = {ctx_st_we, ctx_ld_we};

    generate
        for (genvar gc = 0; gc < NCTX; gc++) begin : g_ctx
            eptlb_ctx_reg u_ctx (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (ctx_we[gc]),
                .wdata   (ctx_wdata),
                .q       (ctx_q[gc]),
                .ctx_pid (ctx_pid[gc]),
                .ctx_as  (ctx_as[gc]),
                .ctx_pr  (ctx_pr[gc])
            );
        end
    endgenerate

    assign ctx_ld_q = ctx_q[0];
    assign ctx_st_q = ctx_q[1];

    // effective context selection
    logic             use_ext;
    logic             sel_st;
    logic [PID_W-1:0] eff_pid;
    logic             eff_as;
    logic             eff_pr;
    logic             eff_wr;
    logic [PN_W-1:0]  req_pn;

    assign use_ext = !req_fetch && (mode == AM_EXT_LOAD || mode == AM_EXT_STORE);
    assign sel_st  = (mode == AM_EXT_STORE);
    assign eff_pid = use_ext ? ctx_pid[sel_st] : cpu_pid0;
    assign eff_as  = req_fetch ? cpu_is : (use_ext ? ctx_as[sel_st] : cpu_ds);
    assign eff_pr  = use_ext ? ctx_pr[sel_st] : cpu_pr;
    assign eff_wr  = req_write && !req_fetch;
    assign req_pn  = req_addr[VA_W-1:OFF_W];

    // main table
    tlb_ent_t          wr_ent;
    logic              arr_hit;
    logic [PN_W-1:0]   arr_rpn;
    logic [PERM_W-1:0] arr_perm;

    assign wr_ent = '{valid: tlb_valid, tid: tlb_tid, ts: tlb_ts,
                      epn: tlb_epn, rpn: tlb_rpn, perm: tlb_perm};

    eptlb_array #(.NENT(NENT), .IDX_W(IDX_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tlb_we),
        .wr_idx     (tlb_idx),
        .wr_ent     (wr_ent),
        .lk_pn      (req_pn),
        .lk_pid0    (eff_pid),
        .lk_pid1_en (!use_ext && (cpu_pid1 != '0)),
        .lk_pid1    (cpu_pid1),
        .lk_pid2_en (!use_ext && (cpu_pid2 != '0)),
        .lk_pid2    (cpu_pid2),
        .lk_as      (eff_as),
        .lk_hit     (arr_hit),
        .lk_rpn     (arr_rpn),
        .lk_perm    (arr_perm)
    );

    // one-entry cache per external mode
    logic [NCTX-1:0]   uc_hit;
    logic [PN_W-1:0]   uc_rpn  [NCTX];
    logic [PERM_W-1:0] uc_perm [NCTX];

    generate
        for (genvar gu = 0; gu < NCTX; gu++) begin : g_uc
            logic this_mode;
            assign this_mode = use_ext && (sel_st == (gu == 1));
            eptlb_ucache u_uc (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush     (ctx_we[gu] || tlb_we),
                .fill      (req_valid && this_mode && arr_hit),
                .fill_pn   (req_pn),
                .fill_rpn  (arr_rpn),
                .fill_perm (arr_perm),
                .lk_pn     (req_pn),
                .lk_hit    (uc_hit[gu]),
                .lk_rpn    (uc_rpn[gu]),
                .lk_perm   (uc_perm[gu])
            );
        end
    endgenerate

    // result formation
    logic              from_uc;
    logic              res_hit;
    logic [PN_W-1:0]   res_rpn;
    logic [PERM_W-1:0] res_perm;
    logic              perm_ok;
    logic              res_fault;

    assign from_uc  = use_ext && uc_hit[sel_st];
    assign res_hit  = from_uc || arr_hit;
    assign res_rpn  = from_uc ? uc_rpn[sel_st]  : arr_rpn;
    assign res_perm = from_uc ? uc_perm[sel_st] : arr_perm;
    assign perm_ok  = eff_pr ? res_perm[eff_wr ? PERM_UW : PERM_UR]
                             : res_perm[eff_wr ? PERM_SW : PERM_SR];
    assign res_fault = res_hit && !perm_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_raddr  <= '0;
            rsp_syn    <= '0;
            rsp_cached <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && res_hit;
            rsp_miss   <= req_valid && !res_hit;
            rsp_fault  <= req_valid && res_fault;
            rsp_cached <= req_valid && from_uc;
            rsp_raddr  <= (req_valid && res_hit && !res_fault)
                          ? {res_rpn, req_addr[OFF_W-1:0]} : '0;
            rsp_syn    <= (req_valid && (!res_hit || res_fault))
                          ? {use_ext, eff_wr} : '0;
        end
    end

    // checks on the response
    p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> rsp_valid);
    p_hit_xor_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    p_fault_on_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);
    p_addr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> (rsp_raddr == '0));
    p_syn_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_syn[SYN_EXT] |-> $past(!req_fetch && (req_mode == 2'd1 || req_mode == 2'd2)));
    p_syn_st_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_syn[SYN_ST] |-> $past(req_write && !req_fetch));
    p_cached_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cached |-> rsp_hit);
    p_fetch_normal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_fetch) |-> (!rsp_cached && !rsp_syn[SYN_EXT]));
endmodule

// File: tb/tb_eptlb_lookup.sv
module tb_eptlb_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_fetch = 0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic [7:0]  cpu_pid0 = 8'd5, cpu_pid1 = 0, cpu_pid2 = 0;
    logic        cpu_pr = 0, cpu_ds = 0, cpu_is = 0;
    logic        ctx_ld_we = 0, ctx_st_we = 0;
    logic [31:0] ctx_wdata = '0;
    logic [31:0] ctx_ld_q, ctx_st_q;
    logic        tlb_we = 0, tlb_valid = 0, tlb_ts = 0;
    logic [2:0]  tlb_idx = '0;
    logic [7:0]  tlb_tid = '0;
    logic [19:0] tlb_epn = '0, tlb_rpn = '0;
    logic [3:0]  tlb_perm = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_cached;
    logic [31:0] rsp_raddr;
    logic [1:0]  rsp_syn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    eptlb_lookup dut (.*);

    typedef struct {
        logic [37:0] v;   // {hit, miss, fault, cached, syn, raddr}
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [37:0] act;
            act = {rsp_hit, rsp_miss, rsp_fault, rsp_cached, rsp_syn, rsp_raddr};
            if (sb.size() == 0) begin
                check(1'b0, "unexpected response", 64'(act), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(act == e.v, e.tag, 64'(act), 64'(e.v));
            end
        end
    end

    task automatic lookup(input logic [31:0] a, input bit wr, input logic [1:0] md,
                          input bit fe, input bit hit, input bit fault,
                          input logic [31:0] ra, input logic [1:0] syn,
                          input bit cached, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_mode = md; req_fetch = fe;
        e.v = {hit, !hit, fault, cached, syn, ra};
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_fetch = 0; req_mode = 0;
    endtask

    task automatic put_entry(input logic [2:0] idx, input bit v, input logic [7:0] tid,
                             input bit ts, input logic [19:0] epn,
                             input logic [19:0] rpn, input logic [3:0] perm);
        @(negedge clk);
        tlb_we = 1; tlb_idx = idx; tlb_valid = v; tlb_tid = tid;
        tlb_ts = ts; tlb_epn = epn; tlb_rpn = rpn; tlb_perm = perm;
        @(negedge clk);
        tlb_we = 0;
    endtask

    task automatic put_ctx(input bit st, input logic [31:0] d);
        @(negedge clk);
        ctx_wdata = d;
        if (st) ctx_st_we = 1; else ctx_ld_we = 1;
        @(negedge clk);
        ctx_ld_we = 0; ctx_st_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rsp_valid == 0, "R1 reset rsp_valid", 64'(rsp_valid), 0);
        check(ctx_ld_q == 0, "R5 reset load ctx", 64'(ctx_ld_q), 0);
        check(ctx_st_q == 0, "R5 reset store ctx", 64'(ctx_st_q), 0);

        // perms: bit3 UR, bit2 UW, bit1 SR, bit0 SW
        put_entry(3'd0, 1, 8'd5,    0, 20'h00010, 20'hAAAAA, 4'b0011);
        put_entry(3'd1, 1, 8'd0,    0, 20'h00020, 20'h12345, 4'b1010);
        put_entry(3'd2, 1, 8'd7,    0, 20'h00030, 20'h0BEEF, 4'b1111);
        put_entry(3'd3, 1, 8'd9,    1, 20'h00040, 20'h0CAFE, 4'b1111);
        put_entry(3'd4, 1, 8'h22,   0, 20'h00050, 20'h00777, 4'b1000);

        lookup(32'h00010ABC, 0, 0, 0, 1, 0, 32'hAAAAAABC, 2'b00, 0, "R1 pid0 hit");
        lookup(32'h00020004, 0, 3, 0, 1, 0, 32'h12345004, 2'b00, 0, "R1 global tid mode3");
        lookup(32'h00020008, 1, 0, 0, 1, 1, 32'h0,        2'b01, 0, "R9 write fault");
        lookup(32'h00030000, 0, 0, 0, 0, 0, 32'h0,        2'b00, 0, "R2 no pid1 miss");
        cpu_pid1 = 8'd7;
        lookup(32'h00030010, 0, 0, 0, 1, 0, 32'h0BEEF010, 2'b00, 0, "R2 pid1 hit");
        cpu_pid1 = 0; cpu_pid2 = 8'd7;
        lookup(32'h00030020, 0, 0, 0, 1, 0, 32'h0BEEF020, 2'b00, 0, "R2 pid2 hit");
        cpu_pid2 = 8'd9;
        lookup(32'h00040010, 0, 0, 0, 0, 0, 32'h0,        2'b00, 0, "R7 ts mismatch miss");
        cpu_ds = 1;
        lookup(32'h00040010, 0, 0, 0, 1, 0, 32'h0CAFE010, 2'b00, 0, "R7 ds match hit");
        cpu_ds = 0; cpu_pid2 = 0; cpu_pr = 1;
        lookup(32'h00010000, 0, 0, 0, 1, 1, 32'h0,        2'b00, 0, "R6 user no UR fault");
        cpu_pr = 0;
        lookup(32'h00099000, 1, 0, 0, 0, 0, 32'h0,        2'b01, 0, "R8 store miss syndrome");

        put_ctx(0, 32'hA03F0122);
        check(ctx_ld_q == 32'h80000022, "R5 load ctx mask", 64'(ctx_ld_q), 64'h80000022);
        check(ctx_st_q == 32'h0, "R5 store ctx untouched", 64'(ctx_st_q), 0);
        lookup(32'h00050100, 0, 1, 0, 1, 0, 32'h00777100, 2'b00, 0, "R3 ext load ctx pid hit");
        lookup(32'h00050200, 0, 1, 0, 1, 0, 32'h00777200, 2'b00, 1, "R10 ext load cached");
        lookup(32'h00010000, 0, 1, 0, 0, 0, 32'h0,        2'b10, 0, "R3 cpu pid0 ignored");
        lookup(32'h00050000, 1, 2, 0, 0, 0, 32'h0,        2'b11, 0, "R4 store ctx used");

        put_ctx(1, 32'h40000009);
        check(ctx_st_q == 32'h40000009, "R5 store ctx value", 64'(ctx_st_q), 64'h40000009);
        lookup(32'h00040020, 1, 2, 0, 1, 0, 32'h0CAFE020, 2'b00, 0, "R4 R7 ext store as hit");
        lookup(32'h00040024, 1, 2, 0, 1, 0, 32'h0CAFE024, 2'b00, 1, "R10 ext store cached");

        put_ctx(0, 32'h80000022);
        lookup(32'h00040030, 1, 2, 0, 1, 0, 32'h0CAFE030, 2'b00, 1, "R11 store cache kept");
        lookup(32'h00050000, 0, 1, 0, 1, 0, 32'h00777000, 2'b00, 0, "R11 load cache flushed");

        put_entry(3'd5, 0, 8'd0, 0, 20'h0, 20'h0, 4'b0000);
        lookup(32'h00040000, 1, 2, 0, 1, 0, 32'h0CAFE000, 2'b00, 0, "R11 table write flush");
        lookup(32'h00050000, 1, 1, 0, 1, 1, 32'h0,        2'b11, 0, "R6 ext priv no UW fault");
        lookup(32'h00050004, 0, 1, 0, 1, 0, 32'h00777004, 2'b00, 1, "R10 fault fills cache");

        lookup(32'h00010000, 0, 1, 1, 1, 0, 32'hAAAAA000, 2'b00, 0, "R12 fetch normal ctx");
        cpu_pr = 1;
        lookup(32'h00010000, 1, 2, 1, 1, 1, 32'h0,        2'b00, 0, "R12 fetch fault no ext");
        cpu_pr = 0;

        put_entry(3'd0, 0, 8'd5, 0, 20'h00010, 20'hAAAAA, 4'b0011);
        lookup(32'h00010000, 0, 0, 0, 0, 0, 32'h0,        2'b00, 0, "R1 invalid entry miss");

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R1 all responses seen", 64'(sb.size()), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule